// File: doc/BRIEF.md
# Echo canceller channel path controller

This block wraps the datapath around one group of two echo cancellers on a 32-channel TDM PCM link. Samples arrive as parallel words, each tagged with its channel number, one channel per clock cycle while `in_valid` is high. Canceller A owns timeslot `SLOT_A` and canceller B owns timeslot `SLOT_B`. For these two timeslots the block produces the receive-side output, the send-side output and the sample presented to the adaptive filter. It also drives the coefficient-clear and adapt-enable strobes of each canceller. The filter arithmetic is not part of the block. An echo estimate supplied by the filter is subtracted from the delayed send sample.

Each canceller takes a 4-bit control word: bit 3 mutes the send output, bit 2 mutes the receive input, bit 1 selects pass-through (bypass) and bit 0 stops adaptation. The words are sampled only on the channel-0 sample that opens a frame. The PCM law select and the cascade bit are sampled at the same point. When the cascade bit is set, the two cancellers act as one filter with twice the tail. Only canceller A's timeslot then carries data, and canceller B's timeslot is filled with quiet code.

Every path is aligned in whole frames through small per-timeslot frame rings. The outputs are registered and appear one cycle after the timeslot's input sample.

Top module: `ecp_path_ctrl`

## Requirements
- R1: Quiet code depends on `law_sel`: 0 (16-bit linear) gives 16'h0000, 1 (sign/magnitude) gives 16'h0080, 2 (mu-law) gives 16'h00FF and 3 (A-law) gives 16'h00D5, with the 8-bit codes in the low byte.
- R2: Outside bypass, `rout_data` for a timeslot carries that timeslot's receive sample from two frames earlier. `sout_data` carries the send sample from three frames earlier minus the `echo_est` given with the current sample. Both appear on the cycle after the timeslot's input, with `out_valid` high and `out_sel` = 0 for A and 1 for B.
- R3: With control bit 1 set, both outputs carry the raw input from two frames earlier. The mute bits and `echo_est` have no effect, and the filter sample is the raw receive input.
- R4: When a canceller enters bypass at a frame boundary, its `coef_clr` strobe is high for exactly one cycle, the cycle after the channel-0 sample. No pulse occurs while bypass is held or when it is left.
- R5: `adapt_en` is high exactly when the latched mode has bypass clear and bit 0 clear. The mute bits do not affect it, and it is low during reset.
- R6: With bit 2 set outside bypass, `rout_data` and `filt_rin` carry quiet code.
- R7: With bit 3 set outside bypass, `sout_data` carries quiet code.
- R8: Control words, the law select and the cascade bit take effect only when the channel-0 sample is taken. Changes later in the frame have no effect until the next frame.
- R9: The send-path difference saturates to 16'h7FFF and 16'h8000.
- R10: With `ext_delay` set, timeslot B's `rout_data`, `sout_data` and `filt_rin` carry quiet code and `ctrl_b` is ignored. Canceller B's `adapt_en` and `coef_clr` then follow canceller A's control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input sample present |
| in_chan | input | 5 | Channel number of the input sample |
| rin_data | input | 16 | Receive-side input sample |
| sin_data | input | 16 | Send-side input sample |
| echo_est | input | 16 | Echo estimate for the current timeslot, two's complement |
| ctrl_a | input | 4 | Canceller A control word |
| ctrl_b | input | 4 | Canceller B control word |
| ext_delay | input | 1 | Cascade both cancellers into one |
| law_sel | input | 2 | PCM law select |
| out_valid | output | 1 | Outputs updated for a group timeslot |
| out_sel | output | 1 | 0 for canceller A, 1 for canceller B |
| rout_data | output | 16 | Receive-side output |
| sout_data | output | 16 | Send-side output |
| filt_rin | output | 16 | Sample to the adaptive filter |
| coef_clr_a | output | 1 | Clear canceller A coefficients |
| coef_clr_b | output | 1 | Clear canceller B coefficients |
| adapt_en_a | output | 1 | Canceller A adaptation enabled |
| adapt_en_b | output | 1 | Canceller B adaptation enabled |

## Verification
Two functions can land in the same cycle. The first is the frame-boundary mode latch, which fires the coefficient-clear pulse and switches the send-path tap. The second is a bypass request raised one channel after that boundary. The bench raises such a request from channel 1 onward and expects no pulse and an unchanged tap for that frame. In the same way, cascade mode is entered with canceller B's control word asking for bypass, and the bench judges that B's strobes follow A and that B's outputs are quiet code in that same frame. Every output word is compared against a frame-history model kept in the bench.

// File: rtl/ecp_pkg.sv
package ecp_pkg;

    localparam int SAMPLE_W = 16;

    typedef enum logic [1:0] {
        LAW_LINEAR = 2'd0,
        LAW_SIGNMAG = 2'd1,
        LAW_MU = 2'd2,
        LAW_A = 2'd3
    } law_e;

    typedef struct packed {
        logic mute_send;
        logic mute_recv;
        logic bypass;
        logic adapt_off;
    } mode_t;

    function automatic logic [SAMPLE_W-1:0] quiet_code(input law_e law);
        case (law)
            LAW_LINEAR: return 16'h0000;
            LAW_SIGNMAG: return 16'h0080;
            LAW_MU: return 16'h00FF;
            default: return 16'h00D5;
        endcase
    endfunction

    function automatic logic [SAMPLE_W-1:0] sat_sub(input logic [SAMPLE_W-1:0] a,
                                                    input logic [SAMPLE_W-1:0] b);
        logic signed [SAMPLE_W:0] diff;
        diff = $signed({a[SAMPLE_W-1], a}) - $signed({b[SAMPLE_W-1], b});
        if (diff[SAMPLE_W] != diff[SAMPLE_W-1]) begin
            return diff[SAMPLE_W] ? {1'b1, {(SAMPLE_W-1){1'b0}}} : {1'b0, {(SAMPLE_W-1){1'b1}}};
        end
        return diff[SAMPLE_W-1:0];
    endfunction

endpackage

// File: rtl/ecp_frame_ring.sv
module ecp_frame_ring #(
    parameter int DEPTH = 3,
    parameter int SLOTS = 2,
    parameter int W = 16,
    localparam int FI_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int SL_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic [SL_W-1:0] slot,
    input logic [FI_W-1:0] wr_frame,
    input logic [W-1:0] wr_data,
    input logic [FI_W-1:0] rd_frame_a,
    input logic [FI_W-1:0] rd_frame_b,
    output logic [W-1:0] rd_a,
    output logic [W-1:0] rd_b
);
    // one stored word per frame and per timeslot; read happens before the write
    logic [W-1:0] mem_q [DEPTH][SLOTS];

    assign rd_a = mem_q[rd_frame_a][slot];
    assign rd_b = mem_q[rd_frame_b][slot];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int f = 0; f < DEPTH; f++) begin
                for (int s = 0; s < SLOTS; s++) begin
                    mem_q[f][s] <= '0;
                end
            end
        end else if (wr_en) begin
            mem_q[wr_frame][slot] <= wr_data;
        end
    end

endmodule

// File: rtl/ecp_mode_reg.sv
module ecp_mode_reg
    import ecp_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic frame_start,
    input mode_t ctrl_in,
    output mode_t mode_eff,
    output logic coef_clr,
    output logic adapt_en
);
    typedef struct packed {
        mode_t mode;
        logic clr;
        logic aen;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        mode_eff = frame_start ? ctrl_in : st_q.mode;
        st_d.mode = mode_eff;
        st_d.aen = !mode_eff.bypass && !mode_eff.adapt_off;
        st_d.clr = frame_start && ctrl_in.bypass && !st_q.mode.bypass;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign coef_clr = st_q.clr;
    assign adapt_en = st_q.aen;

    // R4: clear strobe lasts one cycle
    p_clr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.clr |=> !st_q.clr);

    // R5: a clear pulse never coincides with adaptation
    p_clr_no_adapt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.clr |-> !st_q.aen);

    // R5: adaptation only in a non-bypass, adapting mode
    p_adapt_rule_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.aen |-> (!st_q.mode.bypass && !st_q.mode.adapt_off));

    // R8: latched mode only moves at a frame boundary
    p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(st_q.mode));

endmodule

// File: rtl/ecp_path_ctrl.sv
module ecp_path_ctrl
    import ecp_pkg::*;
#(
    parameter int CHANNELS = 32,
    parameter int SLOT_A = 3,
    parameter int SLOT_B = 4,
    parameter int R_FRAMES = 2,
    parameter int S_FRAMES = 3,
    parameter int BYP_FRAMES = 2,
    localparam int CH_W = $clog2(CHANNELS),
    localparam int RING = S_FRAMES,
    localparam int FI_W = (RING > 1) ? $clog2(RING) : 1,
    localparam int NUM_CANC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic [CH_W-1:0] in_chan,
    input logic [SAMPLE_W-1:0] rin_data,
    input logic [SAMPLE_W-1:0] sin_data,
    input logic [SAMPLE_W-1:0] echo_est,
    input logic [3:0] ctrl_a,
    input logic [3:0] ctrl_b,
    input logic ext_delay,
    input logic [1:0] law_sel,
    output logic out_valid,
    output logic out_sel,
    output logic [SAMPLE_W-1:0] rout_data,
    output logic [SAMPLE_W-1:0] sout_data,
    output logic [SAMPLE_W-1:0] filt_rin,
    output logic coef_clr_a,
    output logic coef_clr_b,
    output logic adapt_en_a,
    output logic adapt_en_b
);
    typedef struct packed {
        logic [FI_W-1:0] fidx;
        logic ext;
        law_e law;
        logic out_valid;
        logic out_sel;
        logic [SAMPLE_W-1:0] rout;
        logic [SAMPLE_W-1:0] sout;
        logic [SAMPLE_W-1:0] filt;
    } st_t;

    st_t st_d, st_q;

    function automatic logic [FI_W-1:0] back(input logic [FI_W-1:0] f, input int d);
        int t;
        t = (int'(f) + RING - d) % RING;
        return FI_W'(t);
    endfunction

    logic frame_start, hit_a, hit_b, wr_en;
    logic [FI_W-1:0] fidx_eff;
    logic ext_eff;
    law_e law_eff;

    always_comb begin
        frame_start = in_valid && (in_chan == '0);
        hit_a = in_valid && (in_chan == CH_W'(SLOT_A));
        hit_b = in_valid && (in_chan == CH_W'(SLOT_B));
        wr_en = hit_a || hit_b;
        if (frame_start) begin
            fidx_eff = (st_q.fidx == FI_W'(RING - 1)) ? '0 : st_q.fidx + 1'b1;
            ext_eff = ext_delay;
            law_eff = law_e'(law_sel);
        end else begin
            fidx_eff = st_q.fidx;
            ext_eff = st_q.ext;
            law_eff = st_q.law;
        end
    end

    // per-canceller mode latches; B follows A's word while cascaded
    mode_t ctrl_src [NUM_CANC];
    mode_t mode_eff [NUM_CANC];
    logic clr_v [NUM_CANC];
    logic aen_v [NUM_CANC];

    assign ctrl_src[0] = mode_t'(ctrl_a);
    assign ctrl_src[1] = ext_eff ? mode_t'(ctrl_a) : mode_t'(ctrl_b);

    generate
        for (genvar k = 0; k < NUM_CANC; k++) begin : g_canc
            ecp_mode_reg u_mode (
                .clk(clk),
                .rst_n(rst_n),
                .frame_start(frame_start),
                .ctrl_in(ctrl_src[k]),
                .mode_eff(mode_eff[k]),
                .coef_clr(clr_v[k]),
                .adapt_en(aen_v[k])
            );
        end
    endgenerate

    assign coef_clr_a = clr_v[0];
    assign coef_clr_b = clr_v[1];
    assign adapt_en_a = aen_v[0];
    assign adapt_en_b = aen_v[1];

    // frame-aligned history for both paths
    logic [SAMPLE_W-1:0] r_norm, r_byp, s_norm, s_byp;

    ecp_frame_ring #(.DEPTH(RING), .SLOTS(NUM_CANC), .W(SAMPLE_W)) u_rin_ring (
        .clk(clk),
        .rst_n(rst_n),
        .wr_en(wr_en),
        .slot(hit_b),
        .wr_frame(fidx_eff),
        .wr_data(rin_data),
        .rd_frame_a(back(fidx_eff, R_FRAMES)),
        .rd_frame_b(back(fidx_eff, BYP_FRAMES)),
        .rd_a(r_norm),
        .rd_b(r_byp)
    );

    ecp_frame_ring #(.DEPTH(RING), .SLOTS(NUM_CANC), .W(SAMPLE_W)) u_sin_ring (
        .clk(clk),
        .rst_n(rst_n),
        .wr_en(wr_en),
        .slot(hit_b),
        .wr_frame(fidx_eff),
        .wr_data(sin_data),
        .rd_frame_a(back(fidx_eff, S_FRAMES)),
        .rd_frame_b(back(fidx_eff, BYP_FRAMES)),
        .rd_a(s_norm),
        .rd_b(s_byp)
    );

    mode_t cur;
    logic [SAMPLE_W-1:0] quiet;

    always_comb begin
        st_d = st_q;
        cur = hit_b ? mode_eff[1] : mode_eff[0];
        quiet = quiet_code(law_eff);
        st_d.fidx = fidx_eff;
        st_d.ext = ext_eff;
        st_d.law = law_eff;
        st_d.out_valid = wr_en;
        if (wr_en) begin
            st_d.out_sel = hit_b;
            if (ext_eff && hit_b) begin
                st_d.rout = quiet;
                st_d.sout = quiet;
                st_d.filt = quiet;
            end else if (cur.bypass) begin
                st_d.rout = r_byp;
                st_d.sout = s_byp;
                st_d.filt = rin_data;
            end else begin
                st_d.rout = cur.mute_recv ? quiet : r_norm;
                st_d.filt = cur.mute_recv ? quiet : rin_data;
                st_d.sout = cur.mute_send ? quiet : sat_sub(s_norm, echo_est);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.out_valid;
    assign out_sel = st_q.out_sel;
    assign rout_data = st_q.rout;
    assign sout_data = st_q.sout;
    assign filt_rin = st_q.filt;

    // R10: cascaded group leaves timeslot B quiet
    p_ext_b_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.out_valid && st_q.out_sel && st_q.ext) |->
            (st_q.rout == quiet_code(st_q.law) && st_q.sout == quiet_code(st_q.law)
             && st_q.filt == quiet_code(st_q.law)));

    // R10: canceller B adapts exactly as A while cascaded
    p_ext_b_adapt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ext |-> (aen_v[1] == aen_v[0]));

endmodule

// File: tb/tb_ecp_path_ctrl.sv
`timescale 1ns/1ps
module tb_ecp_path_ctrl;
    localparam int SA = 3;
    localparam int SB = 4;

    logic clk = 0;
    logic rst_n = 0;
    logic in_valid = 0;
    logic [4:0] in_chan = '0;
    logic [15:0] rin_data = '0, sin_data = '0, echo_est = '0;
    logic [3:0] ctrl_a = '0, ctrl_b = '0;
    logic ext_delay = 0;
    logic [1:0] law_sel = '0;
    logic out_valid, out_sel, coef_clr_a, coef_clr_b, adapt_en_a, adapt_en_b;
    logic [15:0] rout_data, sout_data, filt_rin;

    ecp_path_ctrl #(.SLOT_A(SA), .SLOT_B(SB)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
        .rin_data(rin_data), .sin_data(sin_data), .echo_est(echo_est),
        .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .ext_delay(ext_delay), .law_sel(law_sel),
        .out_valid(out_valid), .out_sel(out_sel), .rout_data(rout_data),
        .sout_data(sout_data), .filt_rin(filt_rin), .coef_clr_a(coef_clr_a),
        .coef_clr_b(coef_clr_b), .adapt_en_a(adapt_en_a), .adapt_en_b(adapt_en_b)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // settings applied at the next frame's channel-0 sample
    logic [3:0] set_a = '0, set_b = '0, late_a = '0;
    bit late_en = 0;
    bit set_ext = 0;
    logic [1:0] set_law = '0;

    // per-frame history kept by the bench
    logic [15:0] hr [64][2];
    logic [15:0] hs [64][2];
    logic [15:0] he [64][2];
    logic [3:0] hc [64][2];
    bit hx [64];
    logic [1:0] hl [64];
    int nf = 0;

    // observations of the latest frame
    logic [15:0] cr [2], cs [2], cf [2];
    bit got [2];
    int clr_cnt [2], clr_ch [2];
    logic aen [2];

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] qcode(input logic [1:0] l);
        case (l)
            2'd0: return 16'h0000;
            2'd1: return 16'h0080;
            2'd2: return 16'h00FF;
            default: return 16'h00D5;
        endcase
    endfunction

    function automatic logic [15:0] satd(input logic [15:0] a, input logic [15:0] b);
        int d;
        d = int'($signed(a)) - int'($signed(b));
        if (d > 32767) d = 32767;
        if (d < -32768) d = -32768;
        return d[15:0];
    endfunction

    function automatic logic [15:0] past_r(input int f, input int k);
        return (f < 0) ? 16'h0000 : hr[f][k];
    endfunction

    function automatic logic [15:0] past_s(input int f, input int k);
        return (f < 0) ? 16'h0000 : hs[f][k];
    endfunction

    task automatic run_frame(input logic [15:0] ra, input logic [15:0] sa, input logic [15:0] ea,
                             input logic [15:0] rb, input logic [15:0] sb, input logic [15:0] eb);
        hr[nf][0] = ra; hs[nf][0] = sa; he[nf][0] = ea;
        hr[nf][1] = rb; hs[nf][1] = sb; he[nf][1] = eb;
        hc[nf][0] = set_a; hc[nf][1] = set_b; hx[nf] = set_ext; hl[nf] = set_law;
        for (int k = 0; k < 2; k++) begin
            got[k] = 0; clr_cnt[k] = 0; clr_ch[k] = -1;
        end
        for (int ch = 0; ch < 32; ch++) begin
            @(negedge clk);
            in_valid = 1;
            in_chan = 5'(ch);
            ctrl_a = (late_en && ch >= 1) ? late_a : set_a;
            ctrl_b = set_b;
            ext_delay = set_ext;
            law_sel = set_law;
            if (ch == SA) begin
                rin_data = ra; sin_data = sa; echo_est = ea;
            end else if (ch == SB) begin
                rin_data = rb; sin_data = sb; echo_est = eb;
            end else begin
                rin_data = 16'(ch * 771); sin_data = 16'(ch * 313 + 9); echo_est = 16'(ch * 5);
            end
            @(posedge clk);
            #1;
            if (out_valid) begin
                got[out_sel] = 1;
                cr[out_sel] = rout_data; cs[out_sel] = sout_data; cf[out_sel] = filt_rin;
            end
            if (coef_clr_a) begin clr_cnt[0]++; clr_ch[0] = ch; end
            if (coef_clr_b) begin clr_cnt[1]++; clr_ch[1] = ch; end
        end
        @(negedge clk);
        in_valid = 0;
        aen[0] = adapt_en_a;
        aen[1] = adapt_en_b;
        nf++;
    endtask

    // compares the last frame's data outputs with the history model
    task automatic check_frame(input string req);
        int f;
        logic [15:0] q, er, es, ef;
        logic [3:0] m;
        f = nf - 1;
        q = qcode(hl[f]);
        for (int k = 0; k < 2; k++) begin
            m = hc[f][k];
            if (hx[f] && k == 1) begin
                er = q; es = q; ef = q;
            end else if (m[1]) begin
                er = past_r(f - 2, k); es = past_s(f - 2, k); ef = hr[f][k];
            end else begin
                er = m[2] ? q : past_r(f - 2, k);
                ef = m[2] ? q : hr[f][k];
                es = m[3] ? q : satd(past_s(f - 3, k), he[f][k]);
            end
            check({req, " valid"}, 16'(got[k]), 16'h0001);
            check({req, " rout"}, cr[k], er);
            check({req, " sout"}, cs[k], es);
            check({req, " filt"}, cf[k], ef);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1;
        check("R5 reset out_valid", 16'(out_valid), 16'h0);
        check("R4 reset coef_clr", {14'b0, coef_clr_a, coef_clr_b}, 16'h0);
        check("R5 reset adapt_en", {14'b0, adapt_en_a, adapt_en_b}, 16'h0);
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic t_normal();
        set_a = 4'b0000; set_b = 4'b0000; set_law = 2'd0;
        for (int i = 0; i < 5; i++) begin
            run_frame(16'(100 + i * 11), 16'(1000 + i * 37), 16'(i * 3),
                      16'(16'hF000 + i), 16'(16'h8100 - i * 99), 16'(16'hFFF0 + i));
            check_frame("R2 normal");
        end
        check("R5 adapt normal A", 16'(aen[0]), 16'h1);
        check("R5 adapt normal B", 16'(aen[1]), 16'h1);
    endtask

    task automatic t_saturate();
        run_frame(16'h0001, 16'd30000, 16'h0, 16'h0002, 16'h8AD0, 16'h0);
        check_frame("R9 sat");
        run_frame(16'h0003, 16'h0, 16'h0, 16'h0004, 16'h0, 16'h0);
        check_frame("R9 sat");
        run_frame(16'h0005, 16'h0, 16'h0, 16'h0006, 16'h0, 16'h0);
        check_frame("R9 sat");
        run_frame(16'h0007, 16'h0, 16'hD8F0, 16'h0008, 16'h0, 16'd10000);
        check_frame("R9 sat");
        check("R9 positive clip", cs[0], 16'h7FFF);
        check("R9 negative clip", cs[1], 16'h8000);
    endtask

    task automatic t_mute();
        set_law = 2'd2;
        set_a = 4'b1100; set_b = 4'b0000;
        for (int i = 0; i < 2; i++) begin
            run_frame(16'h1234, 16'h2345, 16'h0011, 16'h3456, 16'h4567, 16'h0022);
            check_frame("R6 R7 mute");
        end
        check("R6 rout quiet", cr[0], 16'h00FF);
        check("R6 filt quiet", cf[0], 16'h00FF);
        check("R7 sout quiet", cs[0], 16'h00FF);
        check("R5 mute keeps adapt", 16'(aen[0]), 16'h1);
        set_a = 4'b0100;
        run_frame(16'h1111, 16'h2222, 16'h0, 16'h3333, 16'h4444, 16'h0);
        check_frame("R6 recv only");
    endtask

    task automatic t_laws();
        logic [15:0] want [4];
        want[0] = 16'h0000; want[1] = 16'h0080; want[2] = 16'h00FF; want[3] = 16'h00D5;
        set_a = 4'b1100;
        for (int l = 0; l < 4; l++) begin
            set_law = 2'(l);
            run_frame(16'h7777, 16'h6666, 16'h0, 16'h5555, 16'h4444, 16'h0);
            check("R1 quiet rout", cr[0], want[l]);
            check("R1 quiet sout", cs[0], want[l]);
        end
        set_a = 4'b0000; set_law = 2'd0;
    endtask

    task automatic t_adapt_off();
        set_a = 4'b0001;
        run_frame(16'h0A0A, 16'h0B0B, 16'h0101, 16'h0C0C, 16'h0D0D, 16'h0);
        check_frame("R5 adapt off");
        check("R5 adapt off A", 16'(aen[0]), 16'h0);
        check("R5 adapt off B", 16'(aen[1]), 16'h1);
        check("R4 no clr adapt off", 16'(clr_cnt[0]), 16'h0);
    endtask

    task automatic t_bypass();
        set_a = 4'b1110;
        run_frame(16'h1F1F, 16'h2E2E, 16'h0333, 16'h3D3D, 16'h4C4C, 16'h0);
        check_frame("R3 bypass");
        check("R4 clr count", 16'(clr_cnt[0]), 16'h1);
        check("R4 clr cycle", 16'(clr_ch[0]), 16'h0);
        check("R4 B no clr", 16'(clr_cnt[1]), 16'h0);
        check("R5 bypass adapt", 16'(aen[0]), 16'h0);
        run_frame(16'h5B5B, 16'h6A6A, 16'h0444, 16'h7979, 16'h0808, 16'h0);
        check_frame("R3 bypass held");
        check("R4 no clr held", 16'(clr_cnt[0]), 16'h0);
        set_a = 4'b0000;
        run_frame(16'h0102, 16'h0304, 16'h0005, 16'h0607, 16'h0809, 16'h0);
        check_frame("R2 after bypass");
        check("R4 no clr leave", 16'(clr_cnt[0]), 16'h0);
    endtask

    task automatic t_midframe();
        set_a = 4'b0000; late_a = 4'b0010; late_en = 1;
        run_frame(16'h2020, 16'h3030, 16'h0040, 16'h5050, 16'h6060, 16'h0070);
        late_en = 0;
        check_frame("R8 late bypass");
        check("R8 no clr late", 16'(clr_cnt[0]), 16'h0);
        check("R8 adapt kept", 16'(aen[0]), 16'h1);
    endtask

    task automatic t_ext();
        set_ext = 1; set_law = 2'd3; set_a = 4'b0000; set_b = 4'b0010;
        run_frame(16'h0F0F, 16'h0E0E, 16'h0001, 16'h0D0D, 16'h0C0C, 16'h0002);
        check_frame("R10 ext");
        check("R10 B rout quiet", cr[1], 16'h00D5);
        check("R10 B clr ignored", 16'(clr_cnt[1]), 16'h0);
        check("R10 B adapt mirror", 16'(aen[1]), 16'(aen[0]));
        set_a = 4'b0010;
        run_frame(16'h0B0B, 16'h0A0A, 16'h0, 16'h0909, 16'h0808, 16'h0);
        check_frame("R10 ext bypass");
        check("R10 B clr mirror", 16'(clr_cnt[1]), 16'h1);
        check("R10 A clr", 16'(clr_cnt[0]), 16'h1);
        check("R10 B adapt mirror", 16'(aen[1]), 16'h0);
        set_ext = 0; set_a = 4'b0000; set_b = 4'b0000; set_law = 2'd0;
        run_frame(16'h0707, 16'h0606, 16'h0, 16'h0505, 16'h0404, 16'h0);
        check_frame("R10 ext off");
    endtask

    initial begin
        t_reset();
        t_normal();
        t_saturate();
        t_mute();
        t_laws();
        t_adapt_off();
        t_bypass();
        t_midframe();
        t_ext();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule